// File: doc/BRIEF.md
# Half-Duplex Backpressure Jam Controller

This block holds off a shared half-duplex medium by keeping it busy. When backpressure is switched on and no packet of its own is waiting, it tells the transmit path to send an unbroken stream of the alternating-bit byte 55h. Every other station on the segment then either defers or collides. As a result, no new traffic arrives at this node.

When the host asks to send a real packet, the jam stops at once. The block then waits a programmable inter-packet gap, counted in byte clocks, and raises a one-cycle start strobe for the frame engine. It then waits for the frame engine to report that the packet is done or aborted. If backpressure is still on at that point, the jam restarts by itself. Otherwise the block returns to quiet idle.

A host request made while backpressure is off goes through the same gap to the packet, with no jam before or after it. The frame engine, collision detection and retries live outside this block.

Top module: `bp_jam_ctrl`

## Requirements
- R1: After reset, `jam_on`, `pkt_start` and `sending` are 0 and `jam_byte` is 00h.
- R2: With `bp_en` high and no request, `jam_on` is 1 from the cycle after `bp_en` is sampled high in idle, and it stays 1 while nothing else happens.
- R3: A `tx_req` sampled while jamming drops `jam_on` in the very next cycle.
- R4: `pkt_start` is high for exactly one cycle: the G-th cycle after the edge that takes the request. G is `gap_len` sampled at that edge, except that a `gap_len` of 0 counts as 1.
- R5: A `tx_end` sampled while `sending` is high, with `bp_en` high, gives `jam_on` = 1 and `sending` = 0 in the next cycle.
- R6: A `tx_end` sampled while `sending` is high, with `bp_en` low, returns to idle: `jam_on` = 0 and `sending` = 0 in the next cycle.
- R7: Clearing `bp_en` while jamming with no request gives `jam_on` = 0 in the next cycle.
- R8: Clearing `bp_en` during the gap or the packet does not cancel the packet. `pkt_start` still comes on time, and `sending` stays 1 until `tx_end`.
- R9: A `tx_req` sampled in idle leads through the gap to `pkt_start` and `sending` with `jam_on` held at 0 throughout.
- R10: A `tx_req` during the gap or the packet, and a `tx_end` when not sending, have no effect. No extra `pkt_start` occurs, and `sending` and `jam_on` are unchanged.
- R11: `jam_byte` is 55h in every cycle where `jam_on` is 1, and 00h otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bp_en | input | 1 | Backpressure enable (level) |
| tx_req | input | 1 | Host packet request, one-cycle pulse |
| tx_end | input | 1 | Packet finished or aborted, one-cycle pulse |
| gap_len | input | 7 | Inter-packet gap length in byte clocks (0 behaves as 1) |
| jam_on | output | 1 | Transmitter must send the jam pattern |
| jam_byte | output | 8 | Byte to put on the medium while jamming, 00h otherwise |
| pkt_start | output | 1 | One-cycle strobe that launches the packet |
| sending | output | 1 | Packet in progress |

## Verification
The main sequence is run with gap lengths 0, 1, a small value, a mid value and the maximum 127. Each length is tried with backpressure both on and off. The result shows whether the gap counter treats zero specially, whether it is off by one, and whether re-jamming depends on the enable level at packet end. Directed cases then clear the enable in the jam, in the gap and in the packet, to separate an immediate stop from a deferred one. Stray requests during a packet and stray end pulses during the jam show whether the state machine reacts outside its own states.

// File: rtl/bpj_pkg.sv
package bpj_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_JAM  = 2'd1,
    ST_GAP  = 2'd2,
    ST_SEND = 2'd3
  } bpj_state_e;

  // Number of byte clocks spent in the gap for a programmed length.
  function automatic int unsigned gap_cycles(input int unsigned len);
    return (len == 0) ? 1 : len;
  endfunction

endpackage

// File: rtl/bpj_gap_timer.sv
module bpj_gap_timer #(
  parameter int GAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] len,
  input  logic             run,
  output logic             last
);
  localparam logic [GAP_W-1:0] ONE = GAP_W'(1);

  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= GAP_W'(bpj_pkg::gap_cycles(int'(len)));
    end else if (run && cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  assign last = run && (cnt == ONE);

  AST_GAP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt != '0); // R4

endmodule

// File: rtl/bpj_fsm.sv
module bpj_fsm (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bp_en,
  input  logic                  tx_req,
  input  logic                  tx_end,
  input  logic                  gap_last,
  output bpj_pkg::bpj_state_e   state,
  output logic                  gap_load,
  output logic                  gap_run
);
  import bpj_pkg::*;

  bpj_state_e nxt;

  always_comb begin
    nxt      = state;
    gap_load = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (tx_req) begin
          nxt      = ST_GAP;
          gap_load = 1'b1;
        end else if (bp_en) begin
          nxt = ST_JAM;
        end
      end
      ST_JAM: begin
        if (tx_req) begin
          nxt      = ST_GAP;
          gap_load = 1'b1;
        end else if (!bp_en) begin
          nxt = ST_IDLE;
        end
      end
      ST_GAP: begin
        if (gap_last) nxt = ST_SEND;
      end
      ST_SEND: begin
        if (tx_end) nxt = bp_en ? ST_JAM : ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign gap_run = (state == ST_GAP);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  AST_REQ_STOPS_JAM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_JAM && tx_req) |=> state == ST_GAP); // R3
  AST_GAP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP && gap_last) |=> state == ST_SEND); // R4
  AST_END_REJAM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && tx_end && bp_en) |=> state == ST_JAM); // R5
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && tx_end && !bp_en) |=> state == ST_IDLE); // R6
  AST_SEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && !tx_end) |=> state == ST_SEND); // R8

endmodule

// File: rtl/bpj_pattern.sv
module bpj_pattern #(
  parameter int              BYTE_W  = 8,
  parameter logic [BYTE_W-1:0] PATTERN = 8'h55
) (
  input  logic              active,
  output logic [BYTE_W-1:0] data
);
  assign data = active ? PATTERN : '0;
endmodule

// File: rtl/bp_jam_ctrl.sv
module bp_jam_ctrl #(
  parameter int                GAP_W   = 7,
  parameter int                BYTE_W  = 8,
  parameter logic [BYTE_W-1:0] JAM_PAT = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bp_en,
  input  logic              tx_req,
  input  logic              tx_end,
  input  logic [GAP_W-1:0]  gap_len,
  output logic              jam_on,
  output logic [BYTE_W-1:0] jam_byte,
  output logic              pkt_start,
  output logic              sending
);
  import bpj_pkg::*;

  bpj_state_e state;
  logic       gap_load;
  logic       gap_run;
  logic       gap_last;

  bpj_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .bp_en    (bp_en),
    .tx_req   (tx_req),
    .tx_end   (tx_end),
    .gap_last (gap_last),
    .state    (state),
    .gap_load (gap_load),
    .gap_run  (gap_run)
  );

  bpj_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (gap_load),
    .len   (gap_len),
    .run   (gap_run),
    .last  (gap_last)
  );

  assign jam_on    = (state == ST_JAM);
  assign sending   = (state == ST_SEND);
  assign pkt_start = gap_last;

  bpj_pattern #(.BYTE_W(BYTE_W), .PATTERN(JAM_PAT)) u_pat (
    .active (jam_on),
    .data   (jam_byte)
  );

  AST_PATTERN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    jam_on |-> jam_byte == JAM_PAT); // R11
  AST_START_TO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> sending && !pkt_start); // R4
  AST_NO_JAM_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    sending |-> !jam_on && !pkt_start); // R10

endmodule

// File: tb/bp_jam_ctrl_test.sv
`timescale 1ns/100ps
module bp_jam_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bp_en = 1'b0, tx_req = 1'b0, tx_end = 1'b0;
  logic [6:0] gap_len = '0;
  logic       jam_on, pkt_start, sending;
  logic [7:0] jam_byte;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bp_jam_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bp_en(bp_en), .tx_req(tx_req), .tx_end(tx_end),
    .gap_len(gap_len), .jam_on(jam_on), .jam_byte(jam_byte),
    .pkt_start(pkt_start), .sending(sending)
  );

  // {gap_len, backpressure on, expected gap cycles}
  typedef struct packed { logic [6:0] len; logic en; logic [7:0] exp_g; } vec_t;
  localparam vec_t VECS [10] = '{
    '{7'd0,   1'b1, 8'd1},   '{7'd1,   1'b1, 8'd1},
    '{7'd5,   1'b1, 8'd5},   '{7'd12,  1'b0, 8'd12},
    '{7'd127, 1'b1, 8'd127}, '{7'd3,   1'b0, 8'd3},
    '{7'd0,   1'b0, 8'd1},   '{7'd64,  1'b1, 8'd64},
    '{7'd2,   1'b0, 8'd2},   '{7'd96,  1'b0, 8'd96}
  };

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_req(logic [6:0] len);
    gap_len = len; tx_req = 1'b1; step(); tx_req = 1'b0;
  endtask

  task automatic pulse_end();
    tx_end = 1'b1; step(); tx_end = 1'b0;
  endtask

  // Returns the cycle (1-based, after the request edge) in which pkt_start is seen.
  task automatic wait_start(output int n, input bit see_jam);
    n = 1;
    while (!pkt_start && n < 300) begin
      if (jam_on) see_jam = 1;
      step(); n++;
    end
    if (see_jam) chk("R9 jam during gap", 1, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    int n;
    @(negedge clk); step();
    // R1 reset state
    chk("R1 jam_on", jam_on, 0);
    chk("R1 jam_byte", jam_byte, 8'h00);
    chk("R1 pkt_start", pkt_start, 0);
    chk("R1 sending", sending, 0);
    rst_n = 1'b1; step();

    foreach (VECS[i]) begin
      bp_en = VECS[i].en; step();
      chk("R2 jam on enable", jam_on, VECS[i].en);
      chk("R11 jam byte", jam_byte, VECS[i].en ? 8'h55 : 8'h00);
      pulse_req(VECS[i].len);
      chk("R3 jam stops", jam_on, 0);
      wait_start(n, 0);
      chk("R4 gap length", n, VECS[i].exp_g);
      step();
      chk("R4 single strobe", pkt_start, 0);
      chk("R4 sending", sending, 1);
      step();
      pulse_end();
      chk(VECS[i].en ? "R5 rejam" : "R6 idle", jam_on, VECS[i].en);
      chk("R5 R6 send done", sending, 0);
      chk("R11 byte after end", jam_byte, VECS[i].en ? 8'h55 : 8'h00);
      bp_en = 1'b0; step();
      chk("R7 idle", jam_on, 0);
    end

    // R2 jam persists
    bp_en = 1'b1; repeat (20) step();
    chk("R2 jam persists", jam_on, 1);
    // R10 tx_end while jamming ignored
    pulse_end();
    chk("R10 end in jam", jam_on, 1);
    chk("R10 end in jam sending", sending, 0);
    // R7 clear in jam
    bp_en = 1'b0; step();
    chk("R7 clear in jam", jam_on, 0);
    chk("R7 byte", jam_byte, 8'h00);

    // R8 clear during gap
    bp_en = 1'b1; step();
    pulse_req(7'd6);
    bp_en = 1'b0;
    wait_start(n, 0);
    chk("R8 start on time", n, 6);
    step();
    chk("R8 sending", sending, 1);
    // R10 request during packet ignored
    pulse_req(7'd1);
    chk("R10 sending kept", sending, 1);
    chk("R10 no extra start", pkt_start, 0);
    repeat (5) begin step(); chk("R8 sending held", sending, 1); end
    pulse_end();
    chk("R8 idle after end", jam_on, 0);
    chk("R8 not sending", sending, 0);

    // R8 clear during packet; R10 request during gap
    bp_en = 1'b1; step();
    pulse_req(7'd4);
    pulse_req(7'd1);
    wait_start(n, 0);
    chk("R10 gap not restarted", n, 3);
    step();
    bp_en = 1'b0; step();
    chk("R8 sending after clear", sending, 1);
    pulse_end();
    chk("R8 idle", jam_on, 0);
    chk("R8 idle sending", sending, 0);

    summary();
  end
endmodule